// File: doc/BRIEF.md
# Deferred-Fault Token Register File

This block is a general register file in which every entry pairs its data word with a single deferred-fault token. A speculative load that meets a fault condition does not trap. It writes its destination and sets that destination's token. An arithmetic write computes its destination token as the OR of the tokens of its two source registers. A fault therefore travels down a chain of dependent operations without any per-operation report.

A check request names one register. If that register's token is set, the block emits a one-cycle redirect pulse one clock later, carrying the checked index, so that the pipeline can branch to recovery code. Because tokens propagate, a single check on the last register of a dependent chain catches a fault anywhere earlier in that chain.

The check path is a two-state machine. CK_IDLE moves to CK_FIRE on a faulting check. CK_FIRE stays in CK_FIRE on a back-to-back faulting check and returns to CK_IDLE otherwise. CK_IDLE stays in CK_IDLE when no faulting check arrives. The redirect output is high exactly while the machine is in CK_FIRE.

Top module: `dtr_regfile`

## Requirements
- R1: After reset, every register reads as data 0 with token 0 on both read ports.
- R2: A write with `wr_kind` 2'b00 (arithmetic) stores `wr_data` and sets the destination token to the OR of the stored tokens of registers `wr_src_a` and `wr_src_b`, taken before the write.
- R3: A write with `wr_kind` 2'b01 (speculative load) sets the destination token equal to `ld_fault`, so a faulting speculative load is recorded, not trapped.
- R4: A write with `wr_kind` 2'b10 (plain load) or 2'b11 stores token 0 whatever the value of `ld_fault`.
- R5: Register 0 always reads as data 0 with token 0, and writes to it have no effect, including on a check of register 0.
- R6: When a read port addresses the register being written in the same cycle, it returns the new data and the new token (write-first).
- R7: A check request on a register whose token is set (including a token written in the same cycle) raises `redir_valid` in the following cycle, for one cycle per request, with `redir_idx` equal to the checked index.
- R8: A check on a register whose token is clear, or no check at all, leaves `redir_valid` low in the following cycle.
- R9: After a chain of arithmetic writes fed by a faulting speculative load, a check of only the last register of the chain raises a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_idx | input | 7 | Read port A register index |
| ra_data | output | 64 | Read port A data |
| ra_tok | output | 1 | Read port A token |
| rb_idx | input | 7 | Read port B register index |
| rb_data | output | 64 | Read port B data |
| rb_tok | output | 1 | Read port B token |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 7 | Destination register index |
| wr_kind | input | 2 | 00 arithmetic, 01 speculative load, 10/11 plain load |
| wr_src_a | input | 7 | First source index for an arithmetic write |
| wr_src_b | input | 7 | Second source index for an arithmetic write |
| wr_data | input | 64 | Write data |
| ld_fault | input | 1 | Fault condition of a speculative load |
| chk_req | input | 1 | Check request |
| chk_idx | input | 7 | Register to check |
| redir_valid | output | 1 | One-cycle redirect request |
| redir_idx | output | 7 | Index of the register that caused the redirect |

## Verification
The hardest case to reach from the ports is a check that must see a token being created in the same cycle, by a faulting speculative load or by an arithmetic write whose sources carry tokens. The stimulus drives the write and the check together in one cycle and expects the pulse in the next. It also builds multi-step dependent chains through arithmetic writes, so that detection relies only on propagation. Back-to-back faulting checks keep the state machine in CK_FIRE for consecutive cycles, and a sweep over all registers exercises every write kind with a mix of sources.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

    typedef enum logic [1:0] {
        WK_ALU      = 2'b00,
        WK_SPEC     = 2'b01,
        WK_LOAD     = 2'b10,
        WK_LOAD_ALT = 2'b11
    } wr_kind_e;

    typedef enum logic {
        CK_IDLE = 1'b0,
        CK_FIRE = 1'b1
    } chk_state_e;

endpackage

// File: rtl/dtr_token_calc.sv
module dtr_token_calc #(
    parameter int NREGS = 128,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic [1:0]       kind,
    input  logic             fault,
    input  logic [NREGS-1:0] tok_vec,
    input  logic [AW-1:0]    src_a,
    input  logic [AW-1:0]    src_b,
    output logic             new_tok
);
    import dtr_pkg::*;

    wr_kind_e kind_e;
    logic     tok_a;
    logic     tok_b;

    assign kind_e = wr_kind_e'(kind);
    // register 0 never holds a token, so its stored bit is always clear
    assign tok_a  = tok_vec[src_a];
    assign tok_b  = tok_vec[src_b];

    always_comb begin
        unique case (kind_e)
            WK_ALU:      new_tok = tok_a | tok_b;
            WK_SPEC:     new_tok = fault;
            WK_LOAD:     new_tok = 1'b0;
            WK_LOAD_ALT: new_tok = 1'b0;
            default:     new_tok = 1'b0;
        endcase
    end
endmodule

// File: rtl/dtr_read_port.sv
module dtr_read_port #(
    parameter int DW = 64,
    parameter int AW = 7
) (
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] st_data,
    input  logic          st_tok,
    input  logic          wr_live,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_tok,
    output logic [DW-1:0] rd_data,
    output logic          rd_tok
);
    logic hit;

    assign hit = wr_live && (wr_idx == idx);

    always_comb begin
        if (idx == '0) begin
            rd_data = '0;
            rd_tok  = 1'b0;
        end else if (hit) begin
            rd_data = wr_data;
            rd_tok  = wr_tok;
        end else begin
            rd_data = st_data;
            rd_tok  = st_tok;
        end
    end
endmodule

// File: rtl/dtr_check_fsm.sv
module dtr_check_fsm #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_req,
    input  logic          chk_tok,
    input  logic [AW-1:0] chk_idx,
    output logic          redir_valid,
    output logic [AW-1:0] redir_idx
);
    import dtr_pkg::*;

    chk_state_e state_q;
    chk_state_e state_d;
    logic       fault_seen;

    assign fault_seen = chk_req && chk_tok;

    always_comb begin
        unique case (state_q)
            CK_IDLE: state_d = fault_seen ? CK_FIRE : CK_IDLE;
            CK_FIRE: state_d = fault_seen ? CK_FIRE : CK_IDLE;
            default: state_d = CK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CK_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          redir_idx <= '0;
        else if (fault_seen) redir_idx <= chk_idx;
    end

    assign redir_valid = (state_q == CK_FIRE);
endmodule

// File: rtl/dtr_regfile.sv
module dtr_regfile #(
    parameter int NREGS = 128,
    parameter int DW    = 64,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    output logic          ra_tok,
    input  logic [AW-1:0] rb_idx,
    output logic [DW-1:0] rb_data,
    output logic          rb_tok,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [1:0]    wr_kind,
    input  logic [AW-1:0] wr_src_a,
    input  logic [AW-1:0] wr_src_b,
    input  logic [DW-1:0] wr_data,
    input  logic          ld_fault,
    input  logic          chk_req,
    input  logic [AW-1:0] chk_idx,
    output logic          redir_valid,
    output logic [AW-1:0] redir_idx
);
    localparam int NRD = 2;

    logic [DW-1:0]    data_q [NREGS];
    logic [NREGS-1:0] tok_q;
    logic             wr_live;
    logic             new_tok;
    logic             chk_tok;

    logic [AW-1:0]    rp_idx  [NRD];
    logic [DW-1:0]    rp_data [NRD];
    logic             rp_tok  [NRD];

    assign wr_live = wr_en && (wr_idx != '0);

    dtr_token_calc #(.NREGS(NREGS)) u_calc (
        .kind    (wr_kind),
        .fault   (ld_fault),
        .tok_vec (tok_q),
        .src_a   (wr_src_a),
        .src_b   (wr_src_b),
        .new_tok (new_tok)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) data_q[i] <= '0;
            tok_q <= '0;
        end else if (wr_live) begin
            data_q[wr_idx] <= wr_data;
            tok_q[wr_idx]  <= new_tok;
        end
    end

    assign rp_idx[0] = ra_idx;
    assign rp_idx[1] = rb_idx;

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        dtr_read_port #(.DW(DW), .AW(AW)) u_rp (
            .idx     (rp_idx[g]),
            .st_data (data_q[rp_idx[g]]),
            .st_tok  (tok_q[rp_idx[g]]),
            .wr_live (wr_live),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .wr_tok  (new_tok),
            .rd_data (rp_data[g]),
            .rd_tok  (rp_tok[g])
        );
    end

    assign ra_data = rp_data[0];
    assign ra_tok  = rp_tok[0];
    assign rb_data = rp_data[1];
    assign rb_tok  = rp_tok[1];

    always_comb begin
        if (chk_idx == '0)                      chk_tok = 1'b0;
        else if (wr_live && wr_idx == chk_idx)  chk_tok = new_tok;
        else                                    chk_tok = tok_q[chk_idx];
    end

    dtr_check_fsm #(.AW(AW)) u_chk_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_req     (chk_req),
        .chk_tok     (chk_tok),
        .chk_idx     (chk_idx),
        .redir_valid (redir_valid),
        .redir_idx   (redir_idx)
    );
endmodule

// File: rtl/dtr_regfile_chk.sv
module dtr_regfile_chk #(
    parameter int DW = 64,
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ra_idx,
    input logic [DW-1:0] ra_data,
    input logic          ra_tok,
    input logic [AW-1:0] rb_idx,
    input logic [DW-1:0] rb_data,
    input logic          rb_tok,
    input logic          wr_en,
    input logic [AW-1:0] wr_idx,
    input logic [1:0]    wr_kind,
    input logic [DW-1:0] wr_data,
    input logic          ld_fault,
    input logic          chk_req,
    input logic [AW-1:0] chk_idx,
    input logic          redir_valid,
    input logic [AW-1:0] redir_idx
);
    a_r3_spec_fault_sets_tok: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0 && wr_kind == 2'b01 && ld_fault && ra_idx == wr_idx) |-> ra_tok);

    a_r4_load_clears_tok: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0 && wr_kind[1] && rb_idx == wr_idx) |-> !rb_tok);

    a_r5_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx == '0) |-> (ra_data == '0 && !ra_tok));

    a_r5_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_idx == '0) |-> (rb_data == '0 && !rb_tok));

    a_r5_zero_never_checks: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && chk_idx == '0) |=> !redir_valid);

    a_r6_bypass_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0 && ra_idx == wr_idx) |-> (ra_data == wr_data));

    a_r7_redirect_source: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> ($past(chk_req) && redir_idx == $past(chk_idx)));

    a_r8_no_check_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_req |=> !redir_valid);
endmodule

bind dtr_regfile dtr_regfile_chk #(.DW(DW), .AW(AW)) u_dtr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ra_idx      (ra_idx),
    .ra_data     (ra_data),
    .ra_tok      (ra_tok),
    .rb_idx      (rb_idx),
    .rb_data     (rb_data),
    .rb_tok      (rb_tok),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_kind     (wr_kind),
    .wr_data     (wr_data),
    .ld_fault    (ld_fault),
    .chk_req     (chk_req),
    .chk_idx     (chk_idx),
    .redir_valid (redir_valid),
    .redir_idx   (redir_idx)
);

// File: tb/dtr_regfile_test.sv
module dtr_regfile_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NREGS = 128;
    localparam int DW    = 64;
    localparam int AW    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ra_idx = '0, rb_idx = '0, wr_idx = '0, wr_src_a = '0, wr_src_b = '0, chk_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    wr_kind = 2'b10;
    logic          wr_en = 1'b0, ld_fault = 1'b0, chk_req = 1'b0;
    logic [DW-1:0] ra_data, rb_data;
    logic          ra_tok, rb_tok, redir_valid;
    logic [AW-1:0] redir_idx;

    dtr_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_data(ra_data), .ra_tok(ra_tok),
        .rb_idx(rb_idx), .rb_data(rb_data), .rb_tok(rb_tok),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_kind(wr_kind),
        .wr_src_a(wr_src_a), .wr_src_b(wr_src_b), .wr_data(wr_data),
        .ld_fault(ld_fault), .chk_req(chk_req), .chk_idx(chk_idx),
        .redir_valid(redir_valid), .redir_idx(redir_idx)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int            due;
        bit            is_redir;
        logic [AW-1:0] a_idx;
        logic [AW-1:0] b_idx;
        logic [DW-1:0] a_data;
        logic          a_tok;
        logic [DW-1:0] b_data;
        logic          b_tok;
        logic          rv;
        logic [AW-1:0] ri;
        string         tag;
    } item_t;

    item_t         sb_q[$];
    int            cyc = 0;
    int            vectors = 0;
    int            misses = 0;
    bit            done = 1'b0;
    logic [DW-1:0] m_data [NREGS];
    logic          m_tok  [NREGS];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic begin_cycle();
        @(negedge clk);
        wr_en = 1'b0; chk_req = 1'b0; ld_fault = 1'b0;
    endtask

    task automatic put_write(input int idx, input logic [1:0] kind, input logic [DW-1:0] d,
                             input logic f, input int sa, input int sb);
        logic t;
        wr_en = 1'b1; wr_idx = AW'(idx); wr_kind = kind; wr_data = d;
        ld_fault = f; wr_src_a = AW'(sa); wr_src_b = AW'(sb);
        if (kind == 2'b00)      t = m_tok[sa] | m_tok[sb];
        else if (kind == 2'b01) t = f;
        else                    t = 1'b0;
        if (idx != 0) begin
            m_data[idx] = d;
            m_tok[idx]  = t;
        end
    endtask

    task automatic put_read(input int a, input int b, input string tag);
        item_t it;
        ra_idx = AW'(a); rb_idx = AW'(b);
        it = '{due: cyc, is_redir: 1'b0, a_idx: AW'(a), b_idx: AW'(b),
               a_data: m_data[a], a_tok: m_tok[a], b_data: m_data[b], b_tok: m_tok[b],
               rv: 1'b0, ri: '0, tag: tag};
        sb_q.push_back(it);
    endtask

    task automatic put_check(input int idx, input string tag);
        item_t it;
        chk_req = 1'b1; chk_idx = AW'(idx);
        it = '{due: cyc + 1, is_redir: 1'b1, a_idx: '0, b_idx: '0, a_data: '0, a_tok: 1'b0,
               b_data: '0, b_tok: 1'b0, rv: (idx != 0) && m_tok[idx], ri: AW'(idx), tag: tag};
        sb_q.push_back(it);
    endtask

    task automatic expect_quiet(input string tag);
        item_t it;
        it = '{due: cyc + 1, is_redir: 1'b1, a_idx: '0, b_idx: '0, a_data: '0, a_tok: 1'b0,
               b_data: '0, b_tok: 1'b0, rv: 1'b0, ri: '0, tag: tag};
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #1.5;
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                it = sb_q.pop_front();
                vectors++;
                if (it.is_redir) begin
                    if (redir_valid !== it.rv || (it.rv && redir_idx !== it.ri)) begin
                        misses++;
                        $display("FAIL %s redirect: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                                 it.tag, redir_valid, redir_idx, it.rv, it.ri);
                    end
                end else begin
                    if (ra_data !== it.a_data || ra_tok !== it.a_tok) begin
                        misses++;
                        $display("FAIL %s port A r%0d: got %h/%0b, expected %h/%0b",
                                 it.tag, it.a_idx, ra_data, ra_tok, it.a_data, it.a_tok);
                    end
                    if (rb_data !== it.b_data || rb_tok !== it.b_tok) begin
                        misses++;
                        $display("FAIL %s port B r%0d: got %h/%0b, expected %h/%0b",
                                 it.tag, it.b_idx, rb_data, rb_tok, it.b_data, it.b_tok);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < NREGS; i++) begin
            m_data[i] = '0;
            m_tok[i]  = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents, R5: register 0
        begin_cycle(); put_read(0, 5, "R1");  expect_quiet("R8");
        begin_cycle(); put_read(127, 64, "R1");

        // R4: plain load ignores fault input
        begin_cycle(); put_write(1, 2'b10, 64'h1111_2222_3333_4444, 1'b1, 0, 0);
        begin_cycle(); put_read(1, 1, "R4");
        // R3: speculative loads
        begin_cycle(); put_write(2, 2'b01, 64'hDEAD_0000_0000_0002, 1'b1, 0, 0);
        begin_cycle(); put_write(3, 2'b01, 64'h0000_0000_0000_0003, 1'b0, 0, 0); put_read(2, 1, "R3");
        begin_cycle(); put_read(3, 2, "R3");

        // R2: arithmetic propagation
        begin_cycle(); put_write(4, 2'b00, 64'h44, 1'b1, 1, 3);
        begin_cycle(); put_write(5, 2'b00, 64'h55, 1'b0, 1, 2); put_read(4, 3, "R2");
        begin_cycle(); put_write(6, 2'b00, 64'h66, 1'b0, 2, 2); put_read(5, 4, "R2");
        begin_cycle(); put_write(7, 2'b00, 64'h77, 1'b0, 5, 1); put_read(6, 7, "R2");
        begin_cycle(); put_write(10, 2'b00, 64'hAA, 1'b0, 7, 4); put_read(7, 6, "R9");

        // R5: writes to register 0 ignored
        begin_cycle(); put_write(0, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 0, 0); put_read(0, 0, "R5");
        begin_cycle(); put_read(0, 10, "R5"); put_check(0, "R5");

        // R6: write-first bypass on both ports
        begin_cycle(); put_write(8, 2'b01, 64'h8888_8888_0000_0008, 1'b1, 0, 0); put_read(8, 8, "R6");
        begin_cycle(); put_write(8, 2'b10, 64'h0000_0000_0808_0808, 1'b0, 0, 0); put_read(8, 8, "R6");

        // R9: check only end of the chain r2 -> r5 -> r7 -> r10
        begin_cycle(); put_check(10, "R9");
        begin_cycle(); expect_quiet("R7");
        // R8: clean register
        begin_cycle(); put_check(4, "R8");
        begin_cycle(); put_check(3, "R8");
        // R7: back-to-back faulting checks
        begin_cycle(); put_check(2, "R7");
        begin_cycle(); put_check(6, "R7");
        begin_cycle(); put_check(7, "R7");
        begin_cycle(); expect_quiet("R7");
        // R7: token written in the same cycle as the check
        begin_cycle(); put_write(9, 2'b01, 64'h99, 1'b1, 0, 0); put_check(9, "R7");
        begin_cycle(); put_write(11, 2'b00, 64'hBB, 1'b0, 9, 0); put_check(11, "R7");
        // R8: token cleared in the same cycle as the check
        begin_cycle(); put_write(2, 2'b11, 64'h22, 1'b1, 0, 0); put_check(2, "R8");
        begin_cycle(); put_read(2, 9, "R4"); expect_quiet("R8");

        // sweep over all registers and all write kinds
        for (int i = 1; i < NREGS; i++) begin
            begin_cycle();
            put_write(i, 2'(i % 4), {32'(i), ~32'(i * 7)}, ((i >> 1) & 1) == 1, (i * 3) % NREGS, (i * 5) % NREGS);
            put_read(i, (i * 11) % NREGS, (i % 4 == 0) ? "R2" : (i % 4 == 1) ? "R3" : "R4");
        end
        for (int i = 1; i < NREGS; i += 9) begin
            begin_cycle();
            put_read(i, NREGS - i, "R2");
            put_check(i, m_tok[i] ? "R7" : "R8");
        end
        begin_cycle(); expect_quiet("R8");

        repeat (4) begin_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule